// File: doc/BRIEF.md
# Bidirectional I/O Port with Clock-Output Pins

This block is an eight-pin general purpose I/O port on a simple memory-mapped CPU bus. A direction register chooses for each pin whether it drives or listens, and a data register holds the values driven on the upper pins. The two lowest pins are special: when enabled as outputs they carry two system clock signals supplied from outside, not latch data. The port produces per-pin output enables and output values for the pad ring.

Reads are combinational. The direction register cannot be read back and returns all ones. A data register read merges three sources bit by bit: latch bits for driven upper pins, the present clock levels for driven low pins, and synchronized pin levels for undriven pins. Two standby inputs govern the direction register. Hardware standby clears it, which turns off the clock outputs. Software standby leaves it alone, so the port keeps driving.

Top module: `clkpin_gpio_port`

## Requirements
- R1: `pin_oe[i]` equals direction bit i (1 = output, 0 = input). `pin_out[i]` is 0 whenever `pin_oe[i]` is 0.
- R2: A write at 0xFE80 loads the direction register on the next clock edge, and a write at 0xFE82 loads the data latch. Writes to any other address change nothing. A read of any other address, or any cycle with `bus_rd` low, returns 0x00.
- R3: A read at 0xFE80 returns 0xFF, whatever the direction register holds.
- R4: After reset the direction register is 0x03 and data latch bits 7..2 are 0.
- R5: While `hw_stby` is high the direction register is forced to 0x00 on each edge, and this overrides a CPU write in the same cycle. The value stays 0x00 after `hw_stby` falls until the CPU writes it.
- R6: `sw_stby` has no effect. Direction, outputs and CPU writes behave exactly as they do with it low.
- R7: Pin 0 and pin 1 drive `clk_src[0]` and `clk_src[1]` when enabled. A data read returns those clock levels in bits 1..0 in the same cycle as the read.
- R8: A data read returns the latch value in bit i (i >= 2) for an output pin. For an input pin it returns `pin_in[i]` delayed by a two-flop synchronizer, so a change shows up after the second rising edge.
- R9: Data register bits 1..0 cannot be written. A write there never alters `pin_out[1:0]`. When those pins are inputs, bits 1..0 read the synchronized pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby level; clears the direction register |
| sw_stby | input | 1 | Software standby level; no effect on the port |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write strobe, acts on the rising edge |
| bus_rd | input | 1 | Read strobe, combinational read |
| bus_rdata | output | 8 | Read data |
| clk_src | input | 2 | Clock levels for pins 1 and 0 |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
The bench builds the port with its default parameters: eight pins, two clock pins, a 16-bit address, a two-stage synchronizer and a reset direction of 0x03. With these values the exact byte offsets and the 0x03 reset pattern can be checked directly. The split between clock bits and latch bits falls at bit 2, so a single data byte exercises latch, clock and pin sources together. The two-stage synchronizer makes the one-edge and two-edge read latency visible at fixed cycles.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_DATA = 2'd2
  } port_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
  parameter int           W   = 8,
  parameter logic [W-1:0] RST = 8'h03
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hw_stby,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dir <= RST;
    else if (hw_stby) dir <= '0;
    else if (wr_en)   dir <= wdata;
  end
endmodule

// File: rtl/gpio_data_latch.sv
module gpio_data_latch #(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [LW-1:0] wdata,
  output logic [LW-1:0] latch
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     latch <= '0;
    else if (wr_en) latch <= wdata;
  end
endmodule

// File: rtl/clkpin_gpio_port.sv
module clkpin_gpio_port
  import gpio_pkg::*;
#(
  parameter int                WIDTH       = 8,
  parameter int                NCLK        = 2,
  parameter int                ADDR_W      = 16,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DIR_ADDR    = 16'hFE80,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hFE82,
  parameter logic [WIDTH-1:0]  DIR_RST     = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [NCLK-1:0]   clk_src,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  localparam int LW = WIDTH - NCLK;

  function automatic port_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == DIR_ADDR)  return SEL_DIR;
    if (a == DATA_ADDR) return SEL_DATA;
    return SEL_NONE;
  endfunction

  // Per-bit merge: driven pins show their source, undriven pins show the pad.
  function automatic logic [WIDTH-1:0] merge_view(input logic [WIDTH-1:0] dir,
                                                  input logic [WIDTH-1:0] drv,
                                                  input logic [WIDTH-1:0] pad);
    return (dir & drv) | (~dir & pad);
  endfunction

  function automatic logic [WIDTH-1:0] read_mux(input logic rd, input port_sel_e sel,
                                                input logic [WIDTH-1:0] view);
    if (!rd) return '0;
    case (sel)
      SEL_DIR:  return '1;
      SEL_DATA: return view;
      default:  return '0;
    endcase
  endfunction

  port_sel_e        sel;
  logic             dir_wr_ev, dat_wr_ev, dir_rd_ev, sw_hold_ev;
  logic [WIDTH-1:0] dir_q, pad_sync, drv_val;
  logic [LW-1:0]    latch_hi;

  assign sel        = decode(bus_addr);
  assign dir_wr_ev  = bus_wr && (sel == SEL_DIR) && !hw_stby;
  assign dat_wr_ev  = bus_wr && (sel == SEL_DATA);
  assign dir_rd_ev  = bus_rd && (sel == SEL_DIR);
  assign sw_hold_ev = sw_stby && !hw_stby && !dir_wr_ev;

  gpio_dir_reg #(.W(WIDTH), .RST(DIR_RST)) u_dir (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby),
    .wr_en(bus_wr && (sel == SEL_DIR)), .wdata(bus_wdata), .dir(dir_q)
  );

  gpio_data_latch #(.LW(LW)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(dat_wr_ev),
    .wdata(bus_wdata[WIDTH-1:NCLK]), .latch(latch_hi)
  );

  gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pad_sync)
  );

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_drv
    if (gi < NCLK) begin : g_clk
      assign drv_val[gi] = clk_src[gi];
    end else begin : g_lat
      assign drv_val[gi] = latch_hi[gi-NCLK];
    end
  end

  assign pin_oe    = dir_q;
  assign pin_out   = drv_val & dir_q;
  assign bus_rdata = read_mux(bus_rd, sel, merge_view(dir_q, drv_val, pad_sync));
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W    = 8,
  parameter int NCLK = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hw_stby,
  input logic            dir_wr_ev,
  input logic            dir_rd_ev,
  input logic            sw_hold_ev,
  input logic [W-1:0]    bus_wdata,
  input logic [W-1:0]    bus_rdata,
  input logic [NCLK-1:0] clk_src,
  input logic [W-1:0]    pin_out,
  input logic [W-1:0]    pin_oe
);
  AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);  // R1
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr_ev |=> pin_oe == $past(bus_wdata));  // R2
  AST_DIR_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    dir_rd_ev |-> bus_rdata == '1);  // R3
  AST_HW_STBY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> pin_oe == '0);  // R5
  AST_SW_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sw_hold_ev |=> $stable(pin_oe));  // R6
  AST_CLK_PIN0: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[0] |-> pin_out[0] == clk_src[0]);  // R7
  AST_CLK_PIN1: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[1] |-> pin_out[1] == clk_src[1]);  // R7
endmodule

bind clkpin_gpio_port gpio_port_chk #(.W(WIDTH), .NCLK(NCLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .dir_wr_ev(dir_wr_ev),
  .dir_rd_ev(dir_rd_ev), .sw_hold_ev(sw_hold_ev), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .clk_src(clk_src), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/tb_clkpin_gpio_port.sv
module tb_clkpin_gpio_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_DIR = 16'hFE80, A_DAT = 16'hFE82;

  logic clk = 0, rst_n = 0, hw_stby = 0, sw_stby = 0, bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, pin_in = '0, bus_rdata, pin_out, pin_oe;
  logic [1:0]  clk_src = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkpin_gpio_port dut (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .clk_src(clk_src), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1; #1; d = bus_rdata; bus_rd = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    clk_src = 2'b10; #1;
    check("R4 reset dir", pin_oe, 8'h03);
    check("R7 reset clk pins", pin_out, 8'h02);
    rd(A_DIR, d); check("R3 dir reads ones", d, 8'hFF);
    rd(A_DAT, d); check("R4 R7 reset data read", d, 8'h02);
  endtask

  task automatic t_dir_data;
    logic [7:0] d;
    wr(A_DIR, 8'hF0);
    check("R1 oe follows dir", pin_oe, 8'hF0);
    check("R1 out gated", pin_out, 8'h00);
    wr(A_DAT, 8'hA5);
    check("R2 data latch to pins", pin_out, 8'hA0);
    pin_in = 8'h5A; repeat (3) @(negedge clk);
    rd(A_DAT, d); check("R8 mixed read", d, 8'hAA);
    rd(A_DIR, d); check("R3 dir reads ones after write", d, 8'hFF);
    wr(16'hFE81, 8'hFF);
    check("R2 other address no write", pin_out, 8'hA0);
    check("R2 other address dir kept", pin_oe, 8'hF0);
    rd(16'hFE81, d); check("R2 other address reads zero", d, 8'h00);
    bus_addr = A_DAT; #1; check("R2 no strobe reads zero", bus_rdata, 8'h00);
    pin_in = 8'h05; @(negedge clk);
    rd(A_DAT, d); check("R8 one edge old value", d, 8'hAA);
    @(negedge clk);
    rd(A_DAT, d); check("R8 two edges new value", d, 8'hA5);
  endtask

  task automatic t_low_bits;
    logic [7:0] d;
    wr(A_DIR, 8'hFF);
    clk_src = 2'b01; wr(A_DAT, 8'h03);
    check("R9 low bits not latched", pin_out, 8'h01);
    rd(A_DAT, d); check("R7 clock read", d, 8'h01);
    clk_src = 2'b10;
    rd(A_DAT, d); check("R7 clock read same cycle", d, 8'h02);
    check("R7 clock on pins", pin_out, 8'h02);
    wr(A_DIR, 8'hFC);
    pin_in = 8'h01; repeat (3) @(negedge clk);
    rd(A_DAT, d); check("R9 low bits read pin when input", d, 8'h01);
  endtask

  task automatic t_hw_stby;
    wr(A_DIR, 8'hFF);
    @(negedge clk); hw_stby = 1; bus_addr = A_DIR; bus_wdata = 8'h3C; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    check("R5 hw standby clears and wins", pin_oe, 8'h00);
    check("R5 clocks stopped", pin_out, 8'h00);
    hw_stby = 0; repeat (2) @(negedge clk);
    check("R5 stays clear after release", pin_oe, 8'h00);
    wr(A_DIR, 8'h3C);
    check("R5 writable after release", pin_oe, 8'h3C);
  endtask

  task automatic t_sw_stby;
    sw_stby = 1; clk_src = 2'b11; repeat (3) @(negedge clk);
    check("R6 sw standby keeps dir", pin_oe, 8'h3C);
    wr(A_DIR, 8'h03);
    check("R6 write works in sw standby", pin_oe, 8'h03);
    check("R6 clocks keep running", pin_out, 8'h03);
    sw_stby = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_dir_data();
    t_low_bits();
    t_hw_stby();
    t_sw_stby();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule